// File: doc/BRIEF.md
# Five-Port Mesh Router with Contention-Only Input Buffering

This block is one node of a two-dimensional tiled network. It has five input and five output ports: one for the local tile and one for each of the four neighbours (east, west, north, south). Between them sits a five-by-five crossbar. A packet is a head flit followed by zero or more body flits, the last of which is marked as the tail. Both edges of every port use a valid/ready handshake. The head flit carries the destination coordinates. The router steers each packet first along X and then along Y, and hands it to the local port when both coordinates match its own.

The input buffers sit off the main path. When a flit arrives, its input buffer is empty and its output is free, the flit goes straight through switch allocation and the crossbar into the output register. It appears one cycle after it was accepted and never touches storage. A flit that loses allocation, or that finds older flits already queued at its input, is written into that input's FIFO. It is read from the FIFO on a later cycle. Once an output is granted to a head flit, it stays with that input until the tail flit passes. Each output picks among competing heads in round-robin order. Five running counters report buffer writes, buffer reads, allocation requests, crossbar transfers and link transfers, for activity-based power estimation.

Top module: `mesh_router_bypass`

## Requirements
- R1: Flit bits [COORD_W-1:0] hold destination X and [2*COORD_W-1:COORD_W] hold destination Y. Output port index 0 is local, 1 east, 2 west, 3 north and 4 south. A packet goes east if its X is greater than MY_X and west if it is smaller. With X equal, it goes north if its Y is greater than MY_Y and south if it is smaller. With both equal it goes to the local port.
- R2: A flit accepted while its input FIFO is empty and its output is free and uncontested is presented on its output in the next cycle, with no FIFO write.
- R3: A flit that loses allocation is written into its input FIFO and delivered later. No flit is lost or duplicated, and flits from one input to one output keep their order.
- R4: Bit 2*COORD_W marks the tail and bit 2*COORD_W+1 marks the head. After an output grants a head that is not a tail, it carries only flits from that input until that input's tail has passed.
- R5: Each output arbitrates among requesting heads in round-robin order. The search starts at input index 0 after reset and, after each head grant, at the index one above the input just granted, wrapping from 4 to 0.
- R6: While an input FIFO holds flits, a newly arriving flit on that input goes into the FIFO, behind the queued flits.
- R7: While out_valid is high and out_ready is low on a port, out_valid stays high and out_flit stays unchanged on that port.
- R8: in_ready on a port is low exactly when its FIFO holds BUF_DEPTH flits. With one output register and a four-entry FIFO, five flits are taken before a stalled stream is refused.
- R9: The counters add, per cycle: FIFO writes (cnt_buf_wr), FIFO reads (cnt_buf_rd), inputs with a flit presented to allocation (cnt_sw_alloc), flits granted through the crossbar (cnt_xbar) and output handshakes (cnt_link).
- R10: After reset, all out_valid bits are low, all in_ready bits are high and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 5 | Flit valid per input port |
| in_flit | input | 5*FLIT_W | Input flits; port p uses bits [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Input port can take a flit |
| out_valid | output | 5 | Flit valid per output port |
| out_flit | output | 5*FLIT_W | Output flits; port p uses bits [p*FLIT_W +: FLIT_W] |
| out_ready | input | 5 | Downstream accepts the output flit |
| cnt_buf_wr | output | CNT_W | Running count of FIFO writes |
| cnt_buf_rd | output | CNT_W | Running count of FIFO reads |
| cnt_sw_alloc | output | CNT_W | Running count of allocation requests |
| cnt_xbar | output | CNT_W | Running count of crossbar transfers |
| cnt_link | output | CNT_W | Running count of output link transfers |

## Verification
The assertions check, on every cycle, the per-cycle invariants. Each output grants at most one input. A locked output grants nothing to other inputs. A stalled output keeps its flit. A full FIFO takes no write. A flit arriving behind queued flits is always written into the FIFO. Other behaviours show only over a sequence of cycles, so only the bench scenarios can show them: which port each destination reaches, the single-cycle bypass latency, round-robin rotation between rounds of contention, the count of flits taken before backpressure, and the counter totals against the delivered traffic.

// File: rtl/mr_pkg.sv
`timescale 1ns/1ps
package mr_pkg;
  localparam int NPORT = 5;
  localparam int PIDX_W = $clog2(NPORT);

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/mr_route.sv
`timescale 1ns/1ps
module mr_route
  import mr_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  output port_e              dir
);
  localparam logic [COORD_W-1:0] HERE_X = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(MY_Y);

  // X dimension is resolved before Y
  always_comb begin
    if (dest_x > HERE_X)      dir = P_EAST;
    else if (dest_x < HERE_X) dir = P_WEST;
    else if (dest_y > HERE_Y) dir = P_NORTH;
    else if (dest_y < HERE_Y) dir = P_SOUTH;
    else                      dir = P_LOCAL;
  end
endmodule

// File: rtl/mr_in_port.sv
`timescale 1ns/1ps
module mr_in_port
  import mr_pkg::*;
#(
  parameter int FLIT_W  = 128,
  parameter int COORD_W = 3,
  parameter int DEPTH   = 4,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  input  logic              gnt,
  output logic              cand_valid,
  output logic [FLIT_W-1:0] cand_flit,
  output logic              cand_head,
  output logic              cand_tail,
  output port_e             req_dir,
  output logic              push,
  output logic              pop
);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TAIL_BIT = 2 * COORD_W;
  localparam int HEAD_BIT = 2 * COORD_W + 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
  logic [AW:0]       cnt, cnt_nxt;
  port_e             held_dir, held_dir_nxt, xy_dir;
  logic              queued, accept;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // candidate: oldest queued flit first, else the arriving flit (bypass)
  assign queued     = (cnt != '0);
  assign in_ready   = (cnt != FULL_CNT);
  assign accept     = in_valid && in_ready;
  assign cand_valid = queued || in_valid;
  assign cand_flit  = queued ? mem[rd_ptr] : in_flit;
  assign cand_head  = cand_flit[HEAD_BIT];
  assign cand_tail  = cand_flit[TAIL_BIT];

  mr_route #(
    .COORD_W (COORD_W),
    .MY_X    (MY_X),
    .MY_Y    (MY_Y)
  ) u_route (
    .dest_x (cand_flit[0 +: COORD_W]),
    .dest_y (cand_flit[COORD_W +: COORD_W]),
    .dir    (xy_dir)
  );

  // body flits follow the direction latched from their head
  assign req_dir = cand_head ? xy_dir : held_dir;

  // write unless the arriving flit bypassed and won this cycle
  assign push = accept && (queued || !gnt);
  assign pop  = queued && gnt;

  always_comb begin
    wr_ptr_nxt   = wr_ptr;
    rd_ptr_nxt   = rd_ptr;
    cnt_nxt      = cnt;
    held_dir_nxt = held_dir;
    if (push) wr_ptr_nxt = ptr_inc(wr_ptr);
    if (pop)  rd_ptr_nxt = ptr_inc(rd_ptr);
    case ({push, pop})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
    if (gnt && cand_head) held_dir_nxt = xy_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      held_dir <= P_LOCAL;
    end else begin
      wr_ptr   <= wr_ptr_nxt;
      rd_ptr   <= rd_ptr_nxt;
      cnt      <= cnt_nxt;
      held_dir <= held_dir_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_flit;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL_CNT) |-> !push);  // R8
  AST_QUEUE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (queued && in_valid && in_ready) |-> push);  // R6
endmodule

// File: rtl/mr_out_alloc.sv
`timescale 1ns/1ps
module mr_out_alloc
  import mr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] head,
  input  logic [NPORT-1:0] tail,
  input  logic             out_free,
  output logic [NPORT-1:0] gnt
);
  localparam logic [PIDX_W:0] NP_W = (PIDX_W+1)'(NPORT);

  logic              lock_vld, lock_vld_nxt;
  logic [PIDX_W-1:0] lock_id, lock_id_nxt;
  logic [PIDX_W-1:0] ptr, ptr_nxt;
  logic [PIDX_W-1:0] win_id;
  logic              win;
  logic              found;
  logic [PIDX_W:0]   sum;

  function automatic logic [PIDX_W-1:0] wrap_inc(input logic [PIDX_W-1:0] p);
    logic [PIDX_W:0] s;
    s = {1'b0, p} + 1'b1;
    if (s >= NP_W) s = '0;
    return s[PIDX_W-1:0];
  endfunction

  // grant: a locked owner keeps the port, else round-robin over heads
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    sum   = '0;
    if (out_free) begin
      if (lock_vld) begin
        if (req[lock_id]) gnt[lock_id] = 1'b1;
      end else begin
        for (int k = 0; k < NPORT; k++) begin
          sum = {1'b0, ptr} + (PIDX_W+1)'(k);
          if (sum >= NP_W) sum = sum - NP_W;
          if (!found && req[sum[PIDX_W-1:0]] && head[sum[PIDX_W-1:0]]) begin
            gnt[sum[PIDX_W-1:0]] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    win_id = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (gnt[i]) win_id = PIDX_W'(i);
    end
  end
  assign win = |gnt;

  always_comb begin
    lock_vld_nxt = lock_vld;
    lock_id_nxt  = lock_id;
    ptr_nxt      = ptr;
    if (win) begin
      if (tail[win_id]) begin
        lock_vld_nxt = 1'b0;
      end else begin
        lock_vld_nxt = 1'b1;
        lock_id_nxt  = win_id;
      end
      if (!lock_vld) ptr_nxt = wrap_inc(win_id);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_vld <= 1'b0;
      lock_id  <= '0;
      ptr      <= '0;
    end else begin
      lock_vld <= lock_vld_nxt;
      lock_id  <= lock_id_nxt;
      ptr      <= ptr_nxt;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));  // R4
  AST_WORMHOLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_vld |-> ((gnt & ~(NPORT'(1) << lock_id)) == '0));  // R4
  AST_FREE_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_vld && win) |-> head[win_id]);  // R4
  AST_NO_GNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_free |-> (gnt == '0));  // R7
endmodule

// File: rtl/mesh_router_bypass.sv
`timescale 1ns/1ps
module mesh_router_bypass
  import mr_pkg::*;
#(
  parameter int FLIT_W    = 128,
  parameter int COORD_W   = 3,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 32,
  parameter int MY_X      = 2,
  parameter int MY_Y      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*FLIT_W-1:0] out_flit,
  input  logic [NPORT-1:0]        out_ready,
  output logic [CNT_W-1:0]        cnt_buf_wr,
  output logic [CNT_W-1:0]        cnt_buf_rd,
  output logic [CNT_W-1:0]        cnt_sw_alloc,
  output logic [CNT_W-1:0]        cnt_xbar,
  output logic [CNT_W-1:0]        cnt_link
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NPORT-1:0]  cand_valid, cand_head, cand_tail;
  logic [NPORT-1:0]  push_v, pop_v, gnt_in, out_free, link_v;
  logic [FLIT_W-1:0] cand_flit [NPORT];
  port_e             req_dir   [NPORT];
  logic [NPORT-1:0]  req_m     [NPORT];
  logic [NPORT-1:0]  gnt_m     [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    mr_in_port #(
      .FLIT_W  (FLIT_W),
      .COORD_W (COORD_W),
      .DEPTH   (BUF_DEPTH),
      .MY_X    (MY_X),
      .MY_Y    (MY_Y)
    ) u_in (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .in_valid   (in_valid[i]),
      .in_flit    (in_flit[i*FLIT_W +: FLIT_W]),
      .in_ready   (in_ready[i]),
      .gnt        (gnt_in[i]),
      .cand_valid (cand_valid[i]),
      .cand_flit  (cand_flit[i]),
      .cand_head  (cand_head[i]),
      .cand_tail  (cand_tail[i]),
      .req_dir    (req_dir[i]),
      .push       (push_v[i]),
      .pop        (pop_v[i])
    );
  end

  // request matrix per output, grant fold per input
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_m[o][i] = cand_valid[i] && (3'(req_dir[i]) == 3'(o));
      end
    end
    for (int i = 0; i < NPORT; i++) begin
      gnt_in[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) gnt_in[i] = gnt_in[i] | gnt_m[o][i];
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic              ov_nxt;
    logic              load;
    logic [FLIT_W-1:0] xbar_sel;

    assign out_free[o] = !out_valid[o] || out_ready[o];

    mr_out_alloc u_alloc (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .req      (req_m[o]),
      .head     (cand_head),
      .tail     (cand_tail),
      .out_free (out_free[o]),
      .gnt      (gnt_m[o])
    );

    // crossbar column: one-hot grant selects the flit
    always_comb begin
      xbar_sel = '0;
      for (int i = 0; i < NPORT; i++) begin
        xbar_sel = xbar_sel | ({FLIT_W{gnt_m[o][i]}} & cand_flit[i]);
      end
      load   = out_free[o] && (|gnt_m[o]);
      ov_nxt = out_free[o] ? (|gnt_m[o]) : out_valid[o];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) out_valid[o] <= 1'b0;
      else             out_valid[o] <= ov_nxt;
    end

    always_ff @(posedge clk) begin
      if (load) out_flit[o*FLIT_W +: FLIT_W] <= xbar_sel;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (out_valid[o] && !out_ready[o]) |=>
        (out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W])));  // R7
  end

  assign link_v = out_valid & out_ready;

  // activity counters
  logic [CNT_W-1:0] bw_nxt, br_nxt, sa_nxt, xt_nxt, lt_nxt;
  always_comb begin
    bw_nxt = cnt_buf_wr   + CNT_W'($countones(push_v));
    br_nxt = cnt_buf_rd   + CNT_W'($countones(pop_v));
    sa_nxt = cnt_sw_alloc + CNT_W'($countones(cand_valid));
    xt_nxt = cnt_xbar     + CNT_W'($countones(gnt_in));
    lt_nxt = cnt_link     + CNT_W'($countones(link_v));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_buf_wr   <= '0;
      cnt_buf_rd   <= '0;
      cnt_sw_alloc <= '0;
      cnt_xbar     <= '0;
      cnt_link     <= '0;
    end else begin
      cnt_buf_wr   <= bw_nxt;
      cnt_buf_rd   <= br_nxt;
      cnt_sw_alloc <= sa_nxt;
      cnt_xbar     <= xt_nxt;
      cnt_link     <= lt_nxt;
    end
  end

  AST_XBAR_LE_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(gnt_in) <= $countones(cand_valid)));  // R9
endmodule

// File: tb/sim_mesh_router_bypass.sv
`timescale 1ns/1ps
module sim_mesh_router_bypass;
  localparam int FW = 128, CW = 3, NP = 5, CNTW = 32, MX = 2, MY = 2;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst_n;
  logic [NP-1:0]       in_valid, in_ready, out_valid, out_ready;
  logic [NP*FW-1:0]    in_flit, out_flit;
  logic [CNTW-1:0]     c_bw, c_br, c_sa, c_xt, c_lt;

  mesh_router_bypass #(.FLIT_W(FW), .COORD_W(CW), .BUF_DEPTH(4), .CNT_W(CNTW),
                       .MY_X(MX), .MY_Y(MY)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
    .out_ready(out_ready), .cnt_buf_wr(c_bw), .cnt_buf_rd(c_br),
    .cnt_sw_alloc(c_sa), .cnt_xbar(c_xt), .cnt_link(c_lt));

  int total = 0, fails = 0, cyc = 0, delivered = 0, seq = 0;
  bit wd = 0, lat_on = 0, rand_rdy = 0;
  bit hold_low [NP];
  bit stall_prev [NP];
  logic [FW-1:0] held_f [NP];
  int owner [NP];
  logic [FW-1:0] srcq [NP][$];
  logic [FW-1:0] expq [NP*NP][$];
  int            accq [NP*NP][$];
  int            head_log [$];

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int xy(input int dx, input int dy);
    if (dx > MX) return 1;
    if (dx < MX) return 2;
    if (dy > MY) return 3;
    if (dy < MY) return 4;
    return 0;
  endfunction

  task automatic add_pkt(input int src, input int dx, input int dy, input int len);
    for (int j = 0; j < len; j++) begin
      logic [FW-1:0] f;
      f = '0;
      f[0 +: CW]  = CW'(dx);
      f[CW +: CW] = CW'(dy);
      f[2*CW]     = (j == len - 1);
      f[2*CW+1]   = (j == 0);
      f[8 +: 4]   = 4'(src);
      f[12 +: 16] = 16'(seq);
      seq++;
      srcq[src].push_back(f);
    end
  endtask

  task automatic check_out(input int o, input logic [FW-1:0] f);
    int src, k, a;
    logic [FW-1:0] e;
    src = int'(f[8 +: 4]);
    if (src >= NP) src = 0;
    k = src * NP + o;
    delivered++;
    if (expq[k].size() == 0) begin
      chk(0, $sformatf("R1 flit %h from input %0d on output %0d, expected no flit there", f, src, o));
      return;
    end
    e = expq[k].pop_front();
    a = accq[k].pop_front();
    chk(f == e, $sformatf("R3 output %0d flit actual %h expected %h", o, f, e));
    if (lat_on)
      chk(cyc - a == 1, $sformatf("R2 bypass latency actual %0d expected 1", cyc - a));
    if (f[2*CW+1]) begin
      chk(owner[o] < 0, $sformatf("R4 head on output %0d from %0d while owned by %0d, expected free",
                                  o, src, owner[o]));
      if (!f[2*CW]) owner[o] = src;
      head_log.push_back(o * 16 + src);
    end else begin
      chk(owner[o] == src, $sformatf("R4 body on output %0d from %0d, expected owner %0d",
                                     o, src, owner[o]));
      if (f[2*CW]) owner[o] = -1;
    end
  endtask

  // one cycle: sample outputs, then drive next inputs (all at the negedge)
  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT && !wd) begin
      wd = 1;
      chk(0, "R3 watchdog expired, actual hung expected drained");
    end
    for (int o = 0; o < NP; o++) begin
      bit rdy;
      if (stall_prev[o])
        chk(out_valid[o] && out_flit[o*FW +: FW] == held_f[o],
            $sformatf("R7 stalled output %0d actual v=%0b %h expected v=1 %h",
                      o, out_valid[o], out_flit[o*FW +: FW], held_f[o]));
      rdy = hold_low[o] ? 1'b0 : (rand_rdy ? ($urandom_range(0, 3) != 0) : 1'b1);
      out_ready[o] = rdy;
      if (out_valid[o] && rdy) check_out(o, out_flit[o*FW +: FW]);
      stall_prev[o] = out_valid[o] && !rdy && rst_n;
      held_f[o]     = out_flit[o*FW +: FW];
    end
    for (int p = 0; p < NP; p++) begin
      if (srcq[p].size() != 0 && rst_n) begin
        logic [FW-1:0] f;
        f = srcq[p][0];
        in_valid[p] = 1'b1;
        in_flit[p*FW +: FW] = f;
        if (in_ready[p]) begin
          int k;
          k = p * NP + xy(int'(f[0 +: CW]), int'(f[CW +: CW]));
          void'(srcq[p].pop_front());
          expq[k].push_back(f);
          accq[k].push_back(cyc);
        end
      end else begin
        in_valid[p] = 1'b0;
      end
    end
  endtask

  task automatic drain();
    bit busy;
    busy = 1;
    while (busy && !wd) begin
      step();
      busy = (out_valid != '0);
      for (int p = 0; p < NP; p++) if (srcq[p].size() != 0) busy = 1;
      for (int k = 0; k < NP*NP; k++) if (expq[k].size() != 0) busy = 1;
    end
  endtask

  int s_bw, s_br, s_sa, s_xt, s_lt;
  task automatic snap();
    s_bw = int'(c_bw); s_br = int'(c_br); s_sa = int'(c_sa);
    s_xt = int'(c_xt); s_lt = int'(c_lt);
  endtask

  initial begin
    int dxs [5] = '{3, 1, 2, 2, 2};
    int dys [5] = '{2, 2, 5, 0, 2};
    int exps[5] = '{1, 2, 3, 4, 0};
    int acc, last;
    rst_n = 1'b0; in_valid = '0; in_flit = '0; out_ready = '0;
    for (int o = 0; o < NP; o++) begin
      hold_low[o] = 0; stall_prev[o] = 0; owner[o] = -1; held_f[o] = '0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // reset state
    chk(out_valid == '0, $sformatf("R10 out_valid actual %b expected 00000", out_valid));
    chk(in_ready == 5'h1f, $sformatf("R10 in_ready actual %b expected 11111", in_ready));
    chk((c_bw | c_br | c_sa | c_xt | c_lt) == '0, "R10 counters actual nonzero expected 0");

    // routing and single-cycle bypass
    lat_on = 1;
    snap();
    for (int d = 0; d < 5; d++) begin
      add_pkt(0, dxs[d], dys[d], 1);
      drain();
      last = (head_log.size() > 0) ? head_log[head_log.size()-1] / 16 : -1;
      chk(last == exps[d], $sformatf("R1 dest (%0d,%0d) port actual %0d expected %0d",
                                     dxs[d], dys[d], last, exps[d]));
    end
    add_pkt(1, 0, 7, 1);
    drain();
    last = (head_log.size() > 0) ? head_log[head_log.size()-1] / 16 : -1;
    chk(last == 2, $sformatf("R1 west dest port actual %0d expected 2", last));
    chk(int'(c_bw) - s_bw == 0, $sformatf("R2 buffer writes actual %0d expected 0", int'(c_bw) - s_bw));
    chk(int'(c_xt) - s_xt == 6, $sformatf("R9 xbar count actual %0d expected 6", int'(c_xt) - s_xt));
    chk(int'(c_sa) - s_sa == 6, $sformatf("R9 alloc count actual %0d expected 6", int'(c_sa) - s_sa));
    chk(int'(c_lt) - s_lt == 6, $sformatf("R9 link count actual %0d expected 6", int'(c_lt) - s_lt));
    lat_on = 0;

    // contention and round-robin rotation
    snap();
    head_log.delete();
    add_pkt(1, 2, 2, 2);
    add_pkt(2, 2, 2, 2);
    drain();
    last = (head_log.size() >= 2) ? head_log[0] : -1;
    chk(last == 1, $sformatf("R5 first winner actual %0d expected 1", last));
    last = (head_log.size() >= 2) ? head_log[1] : -1;
    chk(last == 2, $sformatf("R5 second winner actual %0d expected 2", last));
    head_log.delete();
    add_pkt(1, 2, 2, 2);
    add_pkt(4, 2, 2, 2);
    drain();
    last = (head_log.size() >= 2) ? head_log[0] : -1;
    chk(last == 4, $sformatf("R5 rotated winner actual %0d expected 4", last));
    chk(int'(c_bw) - s_bw == 4, $sformatf("R3 loser writes actual %0d expected 4", int'(c_bw) - s_bw));
    chk(int'(c_br) - s_br == 4, $sformatf("R3 loser reads actual %0d expected 4", int'(c_br) - s_br));

    // backpressure, fill level and queue-first ordering
    snap();
    hold_low[1] = 1;
    add_pkt(0, 3, 2, 8);
    repeat (12) step();
    acc = 8 - srcq[0].size();
    chk(acc == 5, $sformatf("R8 flits taken under stall actual %0d expected 5", acc));
    chk(in_ready[0] == 1'b0, $sformatf("R8 in_ready when full actual %0b expected 0", in_ready[0]));
    hold_low[1] = 0;
    drain();
    chk(int'(c_bw) - s_bw == 7, $sformatf("R6 queued writes actual %0d expected 7", int'(c_bw) - s_bw));

    // mixed random traffic
    rand_rdy = 1;
    for (int n = 0; n < 300; n++)
      add_pkt($urandom_range(0, 4), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(1, 3));
    drain();
    rand_rdy = 0;
    repeat (4) step();
    chk(int'(c_lt) == delivered, $sformatf("R9 link total actual %0d expected %0d", int'(c_lt), delivered));
    chk(int'(c_xt) == delivered, $sformatf("R9 xbar total actual %0d expected %0d", int'(c_xt), delivered));
    chk(c_bw == c_br, $sformatf("R3 writes %0d vs reads expected equal %0d", c_bw, c_br));
    chk(c_sa >= c_xt, $sformatf("R9 alloc %0d expected at least xbar %0d", c_sa, c_xt));
    for (int p = 0; p < NP; p++)
      chk(in_ready[p], $sformatf("R8 idle in_ready[%0d] actual 0 expected 1", p));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule